// File: doc/BRIEF.md
# Serial PCM Stereo Receiver

This block turns a three-wire serial audio stream into parallel stereo samples. It runs directly on the bit clock and samples the data line and the frame (left/right) clock on each rising edge. Each change of the frame clock ends one channel half. At that change the word just received for that half is taken, sign-extended to 24 bits and stored. When the right half of a frame ends, a single strobe presents both channels of that frame together.

Two framings are supported and selected by a static input. In the right-justified framing, the word ends on the last bit clock of its half, so any extra leading bit clocks are dropped. In the I2S framing, the word begins one bit clock after the frame-clock change, so any bit clocks after the word are dropped. A 2-bit code selects the word width. A polarity bit chooses which frame-clock level means left. In the right-justified framing, a frame of exactly 32 bit clocks is taken as 16-bit data whatever the programmed width.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted and until the first strobe, `valid_o` is low and both sample outputs are zero.
- R2: The width code selects the word width: 00 gives 16, 01 gives 20, 10 gives 24 and 11 gives 18 bits. A word narrower than 24 bits is sign-extended from its most significant received bit.
- R3: In right-justified mode (`cfg_i2s`=0), the sample is the last N bits of the half, received MSB first. The LSB is the bit sampled on the last rising edge before the frame-clock change, and earlier bits in the half have no effect.
- R4: In I2S mode (`cfg_i2s`=1), the MSB is the bit sampled one rising edge after the frame-clock change, and the next N-1 bits complete the word. The word may end on the first edge of the following half. Later bits have no effect, and each half must carry at least N bit clocks.
- R5: With `cfg_lr_swap`=0, a high frame clock marks the left half. With `cfg_lr_swap`=1, a low frame clock marks the left half.
- R6: In right-justified mode, when the preceding complete frame (left-half start to left-half start) lasted exactly 32 bit clocks, both words are taken as 16 bits regardless of the width code. This never applies in I2S mode.
- R7: `valid_o` is a one-cycle pulse that carries the left and right words of one frame. In right-justified mode it is high after the rising edge that first samples the new left level. In I2S mode it is high after the following rising edge. The frame during which the first left-half start after reset is seen gives no pulse.
- R8: Between pulses, `left_o` and `right_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Frame clock; its level selects the channel half |
| sdata | input | 1 | Serial audio data, MSB first |
| cfg_i2s | input | 1 | 0: right-justified framing, 1: I2S framing |
| cfg_wlen | input | 2 | Word-width code (see R2) |
| cfg_lr_swap | input | 1 | Frame-clock polarity (see R5) |
| left_o | output | 24 | Sign-extended left sample |
| right_o | output | 24 | Sign-extended right sample |
| valid_o | output | 1 | One-cycle strobe, new stereo pair on outputs |

## Verification
On every cycle, the bound checker tests four things: the strobe never lasts two cycles, it only follows a left-half start, the outputs hold between strobes, and the applied width is always one of the four legal values, with a 16-bit result sign-extended. Only the bench's streams can show that the right bits are picked. The bench sweeps both framings, all four width codes, both polarities and several half lengths, with junk bits in the unused slots. It compares each result with a value it computes by arithmetic shifts. It also times every strobe against the slot that caused it.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int WIDTH_W  = $clog2(SAMPLE_W + 1);

  typedef enum logic [1:0] {
    WL_16 = 2'b00,
    WL_20 = 2'b01,
    WL_24 = 2'b10,
    WL_18 = 2'b11
  } wlen_code_e;

  // Width code to bit count (non-monotonic code order).
  function automatic logic [WIDTH_W-1:0] wlen_bits(input logic [1:0] code);
    logic [WIDTH_W-1:0] n;
    case (wlen_code_e'(code))
      WL_16:   n = WIDTH_W'(16);
      WL_20:   n = WIDTH_W'(20);
      WL_24:   n = WIDTH_W'(24);
      default: n = WIDTH_W'(18);
    endcase
    return n;
  endfunction

  // Keep the low w bits of raw and copy bit w-1 into every higher bit.
  function automatic logic [SAMPLE_W-1:0] sign_fill(input logic [SAMPLE_W-1:0] raw,
                                                    input logic [WIDTH_W-1:0]  w);
    logic [SAMPLE_W-1:0] res;
    logic                sgn;
    sgn = raw[w - WIDTH_W'(1)];
    for (int i = 0; i < SAMPLE_W; i++) begin
      res[i] = (WIDTH_W'(i) < w) ? raw[i] : sgn;
    end
    return res;
  endfunction
endpackage

// File: rtl/pcm_rx_frame.sv
module pcm_rx_frame #(
  parameter int CNT_W      = 8,
  parameter int PACKED_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck,
  input  logic cfg_i2s,
  input  logic cfg_lr_swap,
  output logic bound,
  output logic frame_start,
  output logic packed_frame
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [1:0]       WARM_DONE = 2'd2;

  logic             lrck_d;
  logic             eff_d;
  logic [1:0]       warm;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] frame_len;
  logic             eff_lr;
  logic             left_now;

  // I2S framing is right-justified framing with the frame clock one bit late.
  assign eff_lr       = cfg_i2s ? lrck_d : lrck;
  assign left_now     = eff_lr ^ cfg_lr_swap;
  assign bound        = (warm == WARM_DONE) && (eff_lr != eff_d);
  assign frame_start  = bound && left_now;
  assign packed_frame = !cfg_i2s && (frame_len == CNT_W'(PACKED_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_d    <= 1'b0;
      eff_d     <= 1'b0;
      warm      <= '0;
      cnt       <= '0;
      frame_len <= '0;
    end else begin
      lrck_d <= lrck;
      eff_d  <= eff_lr;
      if (warm != WARM_DONE) warm <= warm + 2'd1;
      if (frame_start) begin
        frame_len <= cnt;
        cnt       <= CNT_W'(1);
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift import pcm_rx_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sdata,
  input  logic                cfg_i2s,
  input  logic                bound,
  input  logic [WIDTH_W-1:0]  width,
  output logic [SAMPLE_W-1:0] word_raw
);
  logic [SAMPLE_W-1:0] tail_sr;   // last bits before a boundary
  logic [SAMPLE_W-1:0] head_sr;   // first bits after a boundary
  logic [WIDTH_W-1:0]  taken;

  assign word_raw = cfg_i2s ? head_sr : tail_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_sr <= '0;
      head_sr <= '0;
      taken   <= '0;
    end else begin
      tail_sr <= {tail_sr[SAMPLE_W-2:0], sdata};
      if (bound) begin
        head_sr <= {{(SAMPLE_W-1){1'b0}}, sdata};
        taken   <= WIDTH_W'(1);
      end else if (taken < width) begin
        head_sr <= {head_sr[SAMPLE_W-2:0], sdata};
        taken   <= taken + WIDTH_W'(1);
      end
    end
  end
endmodule

// File: rtl/pcm_rx_assemble.sv
module pcm_rx_assemble import pcm_rx_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bound,
  input  logic                frame_start,
  input  logic [SAMPLE_W-1:0] word_raw,
  input  logic [WIDTH_W-1:0]  width,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic [WIDTH_W-1:0]  word_w_o
);
  logic [SAMPLE_W-1:0] left_hold;
  logic                have_left;
  logic                started;
  logic [SAMPLE_W-1:0] filled;

  assign filled = sign_fill(word_raw, width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
      word_w_o  <= WIDTH_W'(16);
      left_hold <= '0;
      have_left <= 1'b0;
      started   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bound && frame_start) begin
        started <= 1'b1;
        if (have_left) begin
          left_o    <= left_hold;
          right_o   <= filled;
          word_w_o  <= width;
          valid_o   <= 1'b1;
          have_left <= 1'b0;
        end
      end else if (bound && started) begin
        left_hold <= filled;
        have_left <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx import pcm_rx_pkg::*; #(
  parameter int CNT_W       = 8,
  parameter int PACKED_LEN  = 32,
  parameter int PACKED_BITS = 16
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                lrck,
  input  logic                sdata,
  input  logic                cfg_i2s,
  input  logic [1:0]          cfg_wlen,
  input  logic                cfg_lr_swap,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic               bound;
  logic               frame_start;
  logic               packed_frame;
  logic [WIDTH_W-1:0] width;
  logic [WIDTH_W-1:0] word_w;
  logic [SAMPLE_W-1:0] word_raw;

  assign width = packed_frame ? WIDTH_W'(PACKED_BITS) : wlen_bits(cfg_wlen);

  pcm_rx_frame #(.CNT_W(CNT_W), .PACKED_LEN(PACKED_LEN)) u_frame (
    .clk(bclk), .rst_n(rst_n), .lrck(lrck), .cfg_i2s(cfg_i2s),
    .cfg_lr_swap(cfg_lr_swap), .bound(bound), .frame_start(frame_start),
    .packed_frame(packed_frame)
  );

  pcm_rx_shift u_shift (
    .clk(bclk), .rst_n(rst_n), .sdata(sdata), .cfg_i2s(cfg_i2s),
    .bound(bound), .width(width), .word_raw(word_raw)
  );

  pcm_rx_assemble u_asm (
    .clk(bclk), .rst_n(rst_n), .bound(bound), .frame_start(frame_start),
    .word_raw(word_raw), .width(width), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .word_w_o(word_w)
  );
endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk import pcm_rx_pkg::*; (
  input logic                clk,
  input logic                rst_n,
  input logic                valid,
  input logic [SAMPLE_W-1:0] left,
  input logic [SAMPLE_W-1:0] right,
  input logic                frame_start,
  input logic [WIDTH_W-1:0]  word_w
);
  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R7
  strobe_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(frame_start));

  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(left) && $stable(right)));

  // R2
  legal_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (word_w == 5'd16 || word_w == 5'd18 || word_w == 5'd20 || word_w == 5'd24));

  // R2
  sign_ext16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && word_w == 5'd16) |-> ($countones(right[23:15]) == 0 || $countones(right[23:15]) == 9));
endmodule

bind pcm_serial_rx pcm_serial_rx_chk u_chk (
  .clk(bclk), .rst_n(rst_n), .valid(valid_o), .left(left_o), .right(right_o),
  .frame_start(frame_start), .word_w(word_w)
);

// File: tb/pcm_serial_rx_bench.sv
module pcm_serial_rx_bench;
  localparam time PERIOD = 10ns;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic        cfg_i2s = 1'b0;
  logic [1:0]  cfg_wlen = 2'b00;
  logic        cfg_lr_swap = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int total = 0;
  int fails = 0;
  int vcnt = 0;
  int tmiss = 0;
  logic exp_next = 1'b0;
  logic [23:0] cap_l, cap_r;

  pcm_serial_rx u_pcm_serial_rx (
    .bclk(bclk), .rst_n(rst_n), .lrck(lrck), .sdata(sdata), .cfg_i2s(cfg_i2s),
    .cfg_wlen(cfg_wlen), .cfg_lr_swap(cfg_lr_swap), .left_o(left_o),
    .right_o(right_o), .valid_o(valid_o)
  );

  always #(PERIOD/2) bclk = ~bclk;

  always @(negedge bclk) begin
    if (valid_o === 1'b1) begin
      vcnt++;
      cap_l = left_o;
      cap_r = right_o;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int code_bits(input logic [1:0] c);
    case (c)
      2'b00: return 16;
      2'b01: return 20;
      2'b10: return 24;
      default: return 18;
    endcase
  endfunction

  // Low n bits, sign-extended.
  function automatic logic [23:0] exp_low(input logic [31:0] x, input int n);
    logic signed [23:0] t;
    t = x[23:0] << (24 - n);
    return t >>> (24 - n);
  endfunction

  // Top n bits of the 32-bit word, sign-extended.
  function automatic logic [23:0] exp_top(input logic [31:0] x, input int n);
    logic signed [23:0] t;
    t = x[31:8];
    return t >>> (24 - n);
  endfunction

  task automatic put(input logic lr, input logic d, input logic want);
    @(negedge bclk);
    if (valid_o !== exp_next) tmiss++;
    lrck = lr;
    sdata = d;
    exp_next = want;
  endtask

  task automatic run_case(input logic i2s, input logic [1:0] code, input logic pol,
                          input int hl, input logic [31:0] xl, input logic [31:0] xr);
    int n;
    string tag;
    logic [23:0] el, er;
    cfg_i2s = i2s; cfg_wlen = code; cfg_lr_swap = pol;
    rst_n = 1'b0; lrck = pol; sdata = 1'b0; exp_next = 1'b0;
    repeat (3) @(negedge bclk);
    // R1: reset state
    chk("R1 left", {8'h0, left_o}, 32'h0);
    chk("R1 right/valid", {7'h0, valid_o, right_o}, 32'h0);
    rst_n = 1'b1;
    vcnt = 0; tmiss = 0;
    for (int k = 0; k < 4; k++) put(pol, 1'b1, 1'b0);
    for (int f = 0; f < 3; f++) begin
      for (int h = 0; h < 2; h++) begin
        for (int i = 0; i < hl; i++) begin
          logic [31:0] cur, prv;
          logic d;
          cur = (h == 0) ? xl : xr;
          prv = (h == 0) ? xr : xl;
          if (i2s) d = (i == 0) ? prv[32 - hl] : cur[32 - i];
          else     d = cur[hl - 1 - i];
          put((h == 0) ? ~pol : pol, d, (h == 0) && (f >= 1) && (i == (i2s ? 1 : 0)));
        end
      end
    end
    for (int i = 0; i < 8; i++)
      put(~pol, (i2s && i == 0) ? xr[32 - hl] : i[0], (i == (i2s ? 1 : 0)));
    n = (!i2s && hl == 16) ? 16 : code_bits(code);
    el = i2s ? exp_top(xl, n) : exp_low(xl, n);
    er = i2s ? exp_top(xr, n) : exp_low(xr, n);
    tag = i2s ? "R4" : ((hl == 16) ? "R6" : "R3");
    if (pol) tag = {tag, "/R5"};
    tag = {tag, "/R2"};
    chk({"R7 strobe count ", tag}, vcnt, 3);
    chk({"R7 strobe timing ", tag}, tmiss, 0);
    chk({"left ", tag}, {8'h0, cap_l}, {8'h0, el});
    chk({"right ", tag}, {8'h0, cap_r}, {8'h0, er});
    // R8: outputs unchanged through the tail slots
    chk("R8 hold", {8'h0, left_o ^ cap_l}, 32'h0);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int idx;
    int hls[3];
    hls[0] = 16; hls[1] = 24; hls[2] = 32;
    idx = 0;
    for (int fm = 0; fm < 2; fm++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 2; p++)
          for (int hi = 0; hi < 3; hi++) begin
            int hl, nb;
            logic [31:0] xl, xr;
            hl = hls[hi];
            nb = code_bits(c[1:0]);
            idx++;
            xl = 32'hA5C3_96F1 ^ (idx * 32'h1357_9BDF);
            xr = {xl[18:0], xl[31:19]} ^ 32'h6E2D_4B87;
            if ((fm == 0 && hl == 16) || hl >= nb)
              run_case(fm[0], c[1:0], p[0], hl, xl, xr);
          end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule